// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block walks a multi-register memory transfer one word at a time. A caller presents a base address, a 16-bit register list, a 2-bit addressing mode, a load/store select, a writeback enable and a privilege bit, and pulses `start_i`. The sequencer counts the set bits of the list and works out where in memory the block begins. It then emits one word request per selected register, lowest register index first, on a valid/ready request port, and the address climbs by one word after each accepted request.

The request port follows valid/ready rules. `req_valid_o` stays high from the first request until the last one is accepted. While `req_ready_i` is low, the address, register index and attribute bits hold steady. A request counts as transferred only in a cycle where both valid and ready are high. After the last transfer, a one-cycle `done_o` pulse carries the updated base value and the flags that tell the caller what else must happen: the program counter was loaded, the saved status word must be restored, or the base register must be rewritten. The control pins `start_i`, `busy_o` and `done_o` are plain levels and pulses.

Top module: `blk_xfer_seq`

## Requirements
- R1: The number of accepted requests in one transfer equals the number of set bits in the 16-bit register list.
- R2: The first request address depends on the count N and on `mode_i`: 0 gives base, 1 gives base+4, 2 gives base-4N+4, 3 gives base-4N. Arithmetic wraps modulo 2^32.
- R3: Requests carry register indices in strictly ascending order, and each request's address is the previous request's address plus 4.
- R4: While `req_valid_o` is high and `req_ready_i` is low, the request (address, register index, attribute bits) stays unchanged on the next cycle.
- R5: `wb_valid_o` is high in the `done_o` cycle exactly when the writeback bit was set. `wb_value_o` then equals base+4N for modes 0 and 1, and base-4N for modes 2 and 3.
- R6: `pc_load_o` is high in the `done_o` cycle exactly when the transfer was a load and list bit 15 was set.
- R7: `status_restore_o` is high in the `done_o` cycle exactly for a load with the privilege bit set and list bit 15 set. In every other transfer with the privilege bit set, each request has `req_user_bank_o` high. Otherwise `req_user_bank_o` is low.
- R8: An empty register list issues no requests. `done_o` appears in the cycle right after `start_i` is taken, and the writeback value equals the base.
- R9: `busy_o` is high from the cycle after `start_i` is taken through the `done_o` cycle. `done_o` lasts one cycle, after which `busy_o` is low.
- R10: A `start_i` pulse while `busy_o` is high is ignored and does not disturb the transfer in progress.
- R11: After reset, `busy_o`, `done_o`, `req_valid_o` and all result flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| base_i | input | 32 | Base register value |
| reglist_i | input | 16 | Register selection list |
| mode_i | input | 2 | Addressing mode: 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| load_i | input | 1 | 1 = load, 0 = store |
| wb_en_i | input | 1 | Write the new base back |
| priv_i | input | 1 | Privilege bit (user bank or status restore) |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| req_valid_o | output | 1 | Word request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | 32 | Word request address |
| req_reg_o | output | 4 | Register index of the request |
| req_load_o | output | 1 | Request direction, 1 = read |
| req_user_bank_o | output | 1 | Transfer uses the user-mode register bank |
| wb_valid_o | output | 1 | Base writeback requested (with done_o) |
| wb_value_o | output | 32 | New base value |
| pc_load_o | output | 1 | Program counter was loaded (with done_o) |
| status_restore_o | output | 1 | Copy saved status word to current (with done_o) |

## Verification
The hardest case to reach from the ports is a stalled request that arrives together with a second `start_i` pulse. The stall exercises the hold rule, and the stray start must leave the captured base and list untouched. The bench reaches it by holding ready low on the first request cycle, driving a new start with a different base, list and mode, and then checking every later address against the original plan. Address wrap below zero in the decrement-before mode and a full 16-register list are also driven on purpose.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

  typedef enum logic [1:0] {
    AM_INC_AFTER  = 2'd0,
    AM_INC_BEFORE = 2'd1,
    AM_DEC_AFTER  = 2'd2,
    AM_DEC_BEFORE = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MOVE = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/bx_popcount.sv
module bx_popcount #(
  parameter int LIST_W = 16,
  localparam int CW = $clog2(LIST_W + 1)
) (
  input  logic [LIST_W-1:0] bits_i,
  output logic [CW-1:0]     count_o
);

  logic [CW-1:0] partial [LIST_W+1];

  assign partial[0] = '0;

  for (genvar g = 0; g < LIST_W; g++) begin : g_acc
    assign partial[g+1] = partial[g] + CW'(bits_i[g]);
  end

  assign count_o = partial[LIST_W];

endmodule

// File: rtl/bx_addr_plan.sv
module bx_addr_plan
  import blk_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CW         = 5,
  parameter int WORD_BYTES = 4,
  localparam int SH = $clog2(WORD_BYTES)
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CW-1:0]     count_i,
  input  addr_mode_e        mode_i,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic [ADDR_W-1:0] new_base_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] up_base;
  logic [ADDR_W-1:0] dn_base;

  assign span    = ADDR_W'(count_i) << SH;
  assign up_base = base_i + span;
  assign dn_base = base_i - span;

  always_comb begin
    unique case (mode_i)
      AM_INC_AFTER: begin
        first_addr_o = base_i;
        new_base_o   = up_base;
      end
      AM_INC_BEFORE: begin
        first_addr_o = base_i + STEP;
        new_base_o   = up_base;
      end
      AM_DEC_AFTER: begin
        first_addr_o = dn_base + STEP;
        new_base_o   = dn_base;
      end
      default: begin
        first_addr_o = dn_base;
        new_base_o   = dn_base;
      end
    endcase
  end

endmodule

// File: rtl/bx_pick_lowest.sv
module bx_pick_lowest #(
  parameter int LIST_W = 16,
  localparam int IW = $clog2(LIST_W)
) (
  input  logic [LIST_W-1:0] mask_i,
  output logic [IW-1:0]     idx_o,
  output logic [LIST_W-1:0] rest_o
);

  always_comb begin
    idx_o = '0;
    for (int i = LIST_W - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IW'(i);
    end
  end

  assign rest_o = mask_i & (mask_i - LIST_W'(1));

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LIST_W     = 16,
  parameter int WORD_BYTES = 4,
  localparam int CW = $clog2(LIST_W + 1),
  localparam int IW = $clog2(LIST_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LIST_W-1:0] reglist_i,
  input  logic [1:0]        mode_i,
  input  logic              load_i,
  input  logic              wb_en_i,
  input  logic              priv_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [IW-1:0]     req_reg_o,
  output logic              req_load_o,
  output logic              req_user_bank_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_value_o,
  output logic              pc_load_o,
  output logic              status_restore_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
  localparam int PC_BIT = LIST_W - 1;

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LIST_W-1:0] mask_q;
  logic [ADDR_W-1:0] wbv_q;
  logic              ld_q, wben_q, priv_q, pc_q;

  logic [CW-1:0]     count;
  logic [ADDR_W-1:0] plan_first;
  logic [ADDR_W-1:0] plan_wb;
  logic [IW-1:0]     cur_idx;
  logic [LIST_W-1:0] rest_mask;
  logic              take_start;
  logic              beat_fire;

  bx_popcount #(.LIST_W(LIST_W)) u_count (
    .bits_i  (reglist_i),
    .count_o (count)
  );

  bx_addr_plan #(
    .ADDR_W     (ADDR_W),
    .CW         (CW),
    .WORD_BYTES (WORD_BYTES)
  ) u_plan (
    .base_i       (base_i),
    .count_i      (count),
    .mode_i       (addr_mode_e'(mode_i)),
    .first_addr_o (plan_first),
    .new_base_o   (plan_wb)
  );

  bx_pick_lowest #(.LIST_W(LIST_W)) u_pick (
    .mask_i (mask_q),
    .idx_o  (cur_idx),
    .rest_o (rest_mask)
  );

  assign take_start = (state_q == ST_IDLE) && start_i;
  assign beat_fire  = (state_q == ST_MOVE) && req_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      wbv_q   <= '0;
      ld_q    <= 1'b0;
      wben_q  <= 1'b0;
      priv_q  <= 1'b0;
      pc_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (take_start) begin
            addr_q  <= plan_first;
            mask_q  <= reglist_i;
            wbv_q   <= plan_wb;
            ld_q    <= load_i;
            wben_q  <= wb_en_i;
            priv_q  <= priv_i;
            pc_q    <= reglist_i[PC_BIT];
            state_q <= (reglist_i == '0) ? ST_DONE : ST_MOVE;
          end
        end
        ST_MOVE: begin
          if (beat_fire) begin
            mask_q <= rest_mask;
            addr_q <= addr_q + STEP;
            if (rest_mask == '0) state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o           = (state_q != ST_IDLE);
  assign done_o           = (state_q == ST_DONE);
  assign req_valid_o      = (state_q == ST_MOVE);
  assign req_addr_o       = addr_q;
  assign req_reg_o        = cur_idx;
  assign req_load_o       = ld_q;
  assign req_user_bank_o  = priv_q && !(ld_q && pc_q);
  assign wb_valid_o       = done_o && wben_q;
  assign wb_value_o       = wbv_q;
  assign pc_load_o        = done_o && ld_q && pc_q;
  assign status_restore_o = done_o && ld_q && pc_q && priv_q;

endmodule

// File: rtl/blk_xfer_chk.sv
module blk_xfer_chk #(
  parameter int ADDR_W     = 32,
  parameter int IW         = 4,
  parameter int WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [IW-1:0]     req_reg_o,
  input logic              req_user_bank_o,
  input logic              wb_valid_o,
  input logic              pc_load_o,
  input logic              status_restore_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(req_reg_o) && $stable(req_user_bank_o)));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ready_i) |=>
      (!req_valid_o || ((req_addr_o == $past(req_addr_o) + STEP) && (req_reg_o > $past(req_reg_o)))));

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!req_valid_o && !done_o));

  assert_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status_restore_o |-> (pc_load_o && done_o));

  assert_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> done_o);

  assert_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> done_o);

endmodule

bind blk_xfer_seq blk_xfer_chk #(
  .ADDR_W     (ADDR_W),
  .IW         (IW),
  .WORD_BYTES (WORD_BYTES)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .start_i          (start_i),
  .busy_o           (busy_o),
  .done_o           (done_o),
  .req_valid_o      (req_valid_o),
  .req_ready_i      (req_ready_i),
  .req_addr_o       (req_addr_o),
  .req_reg_o        (req_reg_o),
  .req_user_bank_o  (req_user_bank_o),
  .wb_valid_o       (wb_valid_o),
  .pc_load_o        (pc_load_o),
  .status_restore_o (status_restore_o)
);

// File: tb/sim_blk_xfer_seq.sv
module sim_blk_xfer_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] reglist_i = '0;
  logic [1:0]  mode_i = '0;
  logic        load_i = 1'b0;
  logic        wb_en_i = 1'b0;
  logic        priv_i = 1'b0;
  logic        req_ready_i = 1'b0;
  logic        busy_o, done_o, req_valid_o, req_load_o, req_user_bank_o;
  logic [31:0] req_addr_o, wb_value_o;
  logic [3:0]  req_reg_o;
  logic        wb_valid_o, pc_load_o, status_restore_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  blk_xfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .reglist_i(reglist_i), .mode_i(mode_i), .load_i(load_i),
    .wb_en_i(wb_en_i), .priv_i(priv_i), .busy_o(busy_o), .done_o(done_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_addr_o(req_addr_o), .req_reg_o(req_reg_o), .req_load_o(req_load_o),
    .req_user_bank_o(req_user_bank_o), .wb_valid_o(wb_valid_o),
    .wb_value_o(wb_value_o), .pc_load_o(pc_load_o),
    .status_restore_o(status_restore_o)
  );

  // {base, list, mode, load, wb, priv, expected first address, expected new base}
  localparam int NV = 7;
  localparam logic [116:0] VEC [NV] = '{
    {32'h0000_1000, 16'h00F0, 2'd0, 1'b1, 1'b1, 1'b0, 32'h0000_1000, 32'h0000_1010},
    {32'h0000_2000, 16'h8001, 2'd1, 1'b1, 1'b1, 1'b1, 32'h0000_2004, 32'h0000_2008},
    {32'h0000_3000, 16'h0007, 2'd2, 1'b0, 1'b1, 1'b0, 32'h0000_2FF8, 32'h0000_2FF4},
    {32'h0000_4000, 16'hFFFF, 2'd3, 1'b1, 1'b0, 1'b0, 32'h0000_3FC0, 32'h0000_3FC0},
    {32'h0000_0004, 16'h0003, 2'd3, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFC, 32'hFFFF_FFFC},
    {32'h0000_5000, 16'h8000, 2'd0, 1'b0, 1'b1, 1'b1, 32'h0000_5000, 32'h0000_5004},
    {32'h0000_6000, 16'h8400, 2'd2, 1'b1, 1'b1, 1'b0, 32'h0000_5FFC, 32'h0000_5FF8}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int popc(input logic [15:0] l);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(l[i]);
    return c;
  endfunction

  function automatic logic [3:0] nth_reg(input logic [15:0] l, input int k);
    int seen = 0;
    for (int i = 0; i < 16; i++) begin
      if (l[i]) begin
        if (seen == k) return 4'(i);
        seen++;
      end
    end
    return 4'hF;
  endfunction

  task automatic run_one(input logic [31:0] b, input logic [15:0] l, input logic [1:0] m,
                         input logic ld, input logic wb, input logic s,
                         input logic [31:0] es, input logic [31:0] ew,
                         input logic [7:0] pat, input bit poke);
    int k = 0;
    int cyc = 0;
    bit seen_done = 0;
    bit stalled = 0;
    logic ub;
    ub = s && !(ld && l[15]);
    @(negedge clk);
    base_i = b; reglist_i = l; mode_i = m; load_i = ld; wb_en_i = wb; priv_i = s;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!seen_done && cyc < 400) begin
      if (poke && cyc == 0) begin
        start_i = 1'b1; base_i = 32'hDEAD_0000; reglist_i = 16'hFFFF; mode_i = 2'd3;
      end else start_i = 1'b0;
      if (cyc == 0) chk(busy_o == 1'b1, "R9 busy after start", 32'(busy_o), 32'd1);
      if (done_o) seen_done = 1;
      else begin
        chk(req_valid_o == 1'b1, "R4 valid held until done", 32'(req_valid_o), 32'd1);
        chk(req_addr_o == es + 32'(4 * k), (k == 0) ? "R2 first address" : (stalled ? "R4 address held" : "R3 address step"),
            req_addr_o, es + 32'(4 * k));
        chk(req_reg_o == nth_reg(l, k), poke ? "R10 register order after stray start" : "R3 register order",
            32'(req_reg_o), 32'(nth_reg(l, k)));
        chk(req_user_bank_o == ub, "R7 user bank", 32'(req_user_bank_o), 32'(ub));
        chk(req_load_o == ld, "R3 request direction", 32'(req_load_o), 32'(ld));
        req_ready_i = pat[cyc % 8];
        stalled = !req_ready_i;
        if (req_ready_i) k++;
        @(negedge clk);
        cyc++;
      end
    end
    start_i = 1'b0;
    req_ready_i = 1'b0;
    chk(seen_done, "R9 done reached", 32'(seen_done), 32'd1);
    chk(k == popc(l), "R1 request count", 32'(k), 32'(popc(l)));
    chk(wb_valid_o == wb, "R5 writeback valid", 32'(wb_valid_o), 32'(wb));
    if (wb) chk(wb_value_o == ew, "R5 writeback value", wb_value_o, ew);
    chk(pc_load_o == (ld && l[15]), "R6 pc load", 32'(pc_load_o), 32'(ld && l[15]));
    chk(status_restore_o == (ld && s && l[15]), "R7 status restore", 32'(status_restore_o), 32'(ld && s && l[15]));
    if (l == 16'h0) chk(cyc == 0, "R8 empty list done next cycle", 32'(cyc), 32'd0);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done one cycle", 32'(done_o), 32'd0);
    chk(busy_o == 1'b0, "R9 idle after done", 32'(busy_o), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL R9 watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0 && req_valid_o == 1'b0, "R11 reset idle",
        {29'd0, busy_o, done_o, req_valid_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && req_valid_o == 1'b0 && wb_valid_o == 1'b0 && pc_load_o == 1'b0 &&
        status_restore_o == 1'b0, "R11 after reset",
        {27'd0, busy_o, req_valid_o, wb_valid_o, pc_load_o, status_restore_o}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      run_one(VEC[v][116:85], VEC[v][84:69], VEC[v][68:67], VEC[v][66], VEC[v][65], VEC[v][64],
              VEC[v][63:32], VEC[v][31:0], (v % 2 == 0) ? 8'hFF : 8'b1011_0010, 1'b0);
    end

    // R8: empty list, increment-before with writeback keeps the base
    run_one(32'h0000_7000, 16'h0000, 2'd1, 1'b1, 1'b1, 1'b1, 32'h0000_7000, 32'h0000_7000, 8'hFF, 1'b0);
    // R8: empty list, decrement-before
    run_one(32'h0000_7100, 16'h0000, 2'd3, 1'b0, 1'b1, 1'b0, 32'h0000_7100, 32'h0000_7100, 8'hFF, 1'b0);
    // R10 with R4: stray start during a stalled first request
    run_one(32'h0000_1000, 16'h00F0, 2'd0, 1'b1, 1'b1, 1'b0, 32'h0000_1000, 32'h0000_1010, 8'b0101_0100, 1'b1);
    // R4: long stall stretches
    run_one(32'h0000_8000, 16'h0421, 2'd1, 1'b0, 1'b1, 1'b0, 32'h0000_8004, 32'h0000_800C, 8'b1000_0000, 1'b0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule